// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects level-sensitive interrupt requests from a 40-line primary bank and a 32-line secondary bank. It presents one interrupt request to the processor. Each request line latches into a pending flag. Each flag is gated by an enable bit. The secondary bank has no output of its own: any secondary line that is pending and enabled feeds primary line 0. When the processor reads a winning index of 0, it knows to look at the secondary status word.

Software reaches the block through a 32-bit, word-addressed register port with a 12-bit byte address. Enable and acknowledge work through separate write-one strobes, so no read-modify-write is ever needed. Primary line n sits in word n/32, bit n%32. The upper primary word therefore carries 8 live bits. A read returns its data one cycle after the request, under the control of a two-state response machine:
- State BUS_IDLE leaves on transition T_ISSUE when a read request arrives, and stays put otherwise.
- State BUS_RESP presents the data. It takes T_CHAIN back into itself for a back-to-back read, or T_DONE back to BUS_IDLE.

Writes take effect at the clock edge on which they are presented, in either state.

Top module: `irqc_cascade`

## Requirements
- R1: After reset, all enables are 0 and all pending flags are 0. `irq_out` is 0, the index reads 0, and each channel map entry c reads back c. Writes of all ones to the enable-clear and acknowledge words are accepted and leave this state intact.
- R2: A write to enable-set (0x020 low word, 0x024 high word) sets each enable bit written as 1. A write to enable-clear (0x030/0x034) clears each enable bit written as 1. Bits written as 0 are unchanged. The enable state reads back at 0x020/0x024.
- R3: A high input sets its pending flag at the next edge, and the flag stays set after the input falls. A write of 1 to acknowledge (0x010/0x014) clears the flag, unless the input is still high, in which case the flag stays set. Raw primary pending flags read at 0x000/0x004.
- R4: `irq_out` is 1 exactly when some primary line is both pending and enabled. A pending line that is disabled does not raise it.
- R5: The read-only word at 0x040 returns, in bits [5:0], the lowest index among primary lines 1..39 that are pending and enabled. It returns 0 if there is none, including when only line 0 is active. Bits [31:6] read 0.
- R6: Secondary flags follow the same rules as R3 and R2, with acknowledge at 0x088, enable-set at 0x090 and enable-clear at 0x098. Status at 0x080 reads pending AND enabled. Any set status bit drives primary line 0 as its input.
- R7: Acknowledging primary line 0 while any secondary status bit is set leaves line 0 pending. Once the secondary status is all zero, acknowledging line 0 clears it.
- R8: The channel map word at 0x200 + 4*c, for c from 0 to 39, stores bits [5:0] of the write data. Bits [31:6] read 0.
- R9: The mode words at 0x050 and 0x060 store 32 bits. The mode words at 0x054 and 0x064 store bits [7:0]. All four read back what was written.
- R10: Reads of any offset not listed as readable read 0. This covers the write-only strobe words, unaligned addresses and unmapped addresses. Writes to unmapped or unaligned addresses change no state.
- R11: A read request raises `bus_rvalid` for exactly the next cycle, with the data. Back-to-back requests give back-to-back responses.
- R12: Primary line n maps to word n/32, bit n%32, in every primary register pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| irq_pri | input | 40 | Primary level-sensitive request lines |
| irq_sec | input | 32 | Secondary level-sensitive request lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench goes after several corner cases:
- Acknowledging a line whose input is still high must leave the flag set. A design that let the clear win would drop a live request.
- Acknowledging primary line 0 while a secondary line is still active must leave line 0 set. A design that got this wrong would lose the cascade and leave the secondary sources stranded.
- The index must skip line 0 when a higher line is pending, and read 0 when only the cascade is active. A wrong design would steer software to the wrong handler.
- Strobe words written with zero bits must leave state alone, and unmapped or unaligned writes must leave every register alone. A design that decoded loosely would corrupt enables.
- Back-to-back reads must each get their own response.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_W = 12;
    localparam int WORD_W = 32;

    localparam logic [ADDR_W-1:0] OFS_PRAW  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_PACK  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_PENS  = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_PENC  = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_IDX   = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_PMODE = 12'h050;
    localparam logic [ADDR_W-1:0] OFS_TMODE = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_SSTAT = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_SACK  = 12'h088;
    localparam logic [ADDR_W-1:0] OFS_SENS  = 12'h090;
    localparam logic [ADDR_W-1:0] OFS_SENC  = 12'h098;
    localparam logic [ADDR_W-1:0] OFS_CHAN  = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_HI    = 12'h004;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_t;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    output logic [N-1:0] pend,
    output logic [N-1:0] en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            en   <= '0;
        end else begin
            pend <= (pend & ~ack) | lvl;
            en   <= (en | en_set) & ~en_clr;
        end
    end

    // R3
    lvl_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lvl) |=> ((pend & $past(lvl)) == $past(lvl)));
    // R3
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack & ~lvl)) |=> ((pend & $past(ack & ~lvl)) == '0));
    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_set) |=> ((en & $past(en_set & ~en_clr)) == $past(en_set & ~en_clr)));
    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_clr) |=> ((en & $past(en_clr)) == '0));
endmodule

// File: rtl/irqc_lowidx.sv
module irqc_lowidx #(
    parameter int N = 40,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] act,
    output logic [W-1:0] idx,
    output logic         any
);
    always_comb begin
        logic found;
        found = 1'b0;
        idx   = '0;
        for (int i = 1; i < N; i++) begin
            if (act[i] && !found) begin
                idx   = W'(i);
                found = 1'b1;
            end
        end
        any = |act;
    end
endmodule

// File: rtl/irqc_busfsm.sv
module irqc_busfsm
    import irqc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [DW-1:0] rd_word,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    bus_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_IDLE: if (rd_req) state_nx = BUS_RESP;          // T_ISSUE
            BUS_RESP: state_nx = rd_req ? BUS_RESP : BUS_IDLE;  // T_CHAIN / T_DONE
            default:  state_nx = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_req) rdata <= rd_word;
    end

    assign rvalid = (state == BUS_RESP);

    // R11
    rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);
    // R11
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid);
endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade
    import irqc_pkg::*;
#(
    parameter int NPRI = 40,
    parameter int NSEC = 32,
    parameter int CHW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [NPRI-1:0]   irq_pri,
    input  logic [NSEC-1:0]   irq_sec,
    output logic              irq_out
);
    localparam int HI_W  = NPRI - WORD_W;
    localparam int IDX_W = $clog2(NPRI);
    localparam logic [ADDR_W-1:0] CHAN_END = OFS_CHAN + ADDR_W'(4 * NPRI);

    logic wr;
    logic [NPRI-1:0] p_ack, p_set, p_clr, p_pend, p_en, p_lvl, p_act;
    logic [NSEC-1:0] s_ack, s_set, s_clr, s_pend, s_en, s_act;
    logic            sec_any;
    logic [IDX_W-1:0] idx;
    logic [WORD_W-1:0] pmode_lo, tmode_lo, rd_comb;
    logic [HI_W-1:0]   pmode_hi, tmode_hi;
    logic [CHW-1:0]    chmap [NPRI];
    logic              chan_hit;
    logic [ADDR_W-1:0] chan_off;
    logic [IDX_W-1:0]  chan_sel;

    assign wr = bus_req & bus_we;

    // write strobe decode
    always_comb begin
        p_ack = '0; p_set = '0; p_clr = '0;
        s_ack = '0; s_set = '0; s_clr = '0;
        if (wr) begin
            case (bus_addr)
                OFS_PACK:          p_ack[WORD_W-1:0]    = bus_wdata;
                OFS_PACK + OFS_HI: p_ack[NPRI-1:WORD_W] = bus_wdata[HI_W-1:0];
                OFS_PENS:          p_set[WORD_W-1:0]    = bus_wdata;
                OFS_PENS + OFS_HI: p_set[NPRI-1:WORD_W] = bus_wdata[HI_W-1:0];
                OFS_PENC:          p_clr[WORD_W-1:0]    = bus_wdata;
                OFS_PENC + OFS_HI: p_clr[NPRI-1:WORD_W] = bus_wdata[HI_W-1:0];
                OFS_SACK:          s_ack = bus_wdata[NSEC-1:0];
                OFS_SENS:          s_set = bus_wdata[NSEC-1:0];
                OFS_SENC:          s_clr = bus_wdata[NSEC-1:0];
                default: ;
            endcase
        end
    end

    irqc_bank #(.N(NSEC)) u_sec (
        .clk(clk), .rst_n(rst_n), .lvl(irq_sec), .ack(s_ack),
        .en_set(s_set), .en_clr(s_clr), .pend(s_pend), .en(s_en)
    );

    assign s_act   = s_pend & s_en;
    assign sec_any = |s_act;
    assign p_lvl   = {irq_pri[NPRI-1:1], irq_pri[0] | sec_any};

    irqc_bank #(.N(NPRI)) u_pri (
        .clk(clk), .rst_n(rst_n), .lvl(p_lvl), .ack(p_ack),
        .en_set(p_set), .en_clr(p_clr), .pend(p_pend), .en(p_en)
    );

    assign p_act = p_pend & p_en;

    irqc_lowidx #(.N(NPRI), .W(IDX_W)) u_idx (
        .act(p_act), .idx(idx), .any(irq_out)
    );

    // channel map and mode words
    assign chan_off = bus_addr - OFS_CHAN;
    assign chan_sel = IDX_W'(chan_off >> 2);
    assign chan_hit = (bus_addr >= OFS_CHAN) && (bus_addr < CHAN_END) && (bus_addr[1:0] == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NPRI; c++) chmap[c] <= CHW'(c);
        end else if (wr && chan_hit) begin
            chmap[chan_sel] <= bus_wdata[CHW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmode_lo <= '0; pmode_hi <= '0;
            tmode_lo <= '0; tmode_hi <= '0;
        end else if (wr) begin
            case (bus_addr)
                OFS_PMODE:          pmode_lo <= bus_wdata;
                OFS_PMODE + OFS_HI: pmode_hi <= bus_wdata[HI_W-1:0];
                OFS_TMODE:          tmode_lo <= bus_wdata;
                OFS_TMODE + OFS_HI: tmode_hi <= bus_wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rd_comb = '0;
        if (chan_hit) begin
            rd_comb[CHW-1:0] = chmap[chan_sel];
        end else begin
            case (bus_addr)
                OFS_PRAW:           rd_comb = p_pend[WORD_W-1:0];
                OFS_PRAW + OFS_HI:  rd_comb[HI_W-1:0] = p_pend[NPRI-1:WORD_W];
                OFS_PENS:           rd_comb = p_en[WORD_W-1:0];
                OFS_PENS + OFS_HI:  rd_comb[HI_W-1:0] = p_en[NPRI-1:WORD_W];
                OFS_IDX:            rd_comb[IDX_W-1:0] = idx;
                OFS_PMODE:          rd_comb = pmode_lo;
                OFS_PMODE + OFS_HI: rd_comb[HI_W-1:0] = pmode_hi;
                OFS_TMODE:          rd_comb = tmode_lo;
                OFS_TMODE + OFS_HI: rd_comb[HI_W-1:0] = tmode_hi;
                OFS_SSTAT:          rd_comb[NSEC-1:0] = s_act;
                OFS_SENS:           rd_comb[NSEC-1:0] = s_en;
                default: ;
            endcase
        end
    end

    irqc_busfsm #(.DW(WORD_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .rd_req(bus_req & ~bus_we),
        .rd_word(rd_comb), .rvalid(bus_rvalid), .rdata(bus_rdata)
    );

    // R6
    cascade_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_any |=> p_pend[0]);
    // R5
    idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == '0) |-> ((p_act >> 1) == '0));
    // R5
    idx_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0) |-> p_act[idx]);
    // R4
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((idx != '0) || p_act[0]));
endmodule

// File: tb/sim_irqc_cascade.sv
`timescale 1ns/1ps
module sim_irqc_cascade;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [39:0] irq_pri = '0;
    logic [31:0] irq_sec = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqc_cascade u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_pri(irq_pri), .irq_sec(irq_sec), .irq_out(irq_out)
    );

    // behavioural reference model
    logic [39:0] m_pp, m_pe, m_lv;
    logic [31:0] m_sp, m_se;
    logic [5:0]  m_ch [40];
    logic [31:0] m_pm0, m_tm0, m_rd;
    logic [7:0]  m_pm1, m_tm1;
    logic        m_rv, m_irq, m_sa;

    function automatic int m_idx();
        for (int i = 1; i < 40; i++) if (m_pp[i] && m_pe[i]) return i;
        return 0;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        if (a >= 12'h200 && a < 12'h2A0 && a[1:0] == 2'b00)
            return {26'b0, m_ch[(a - 12'h200) >> 2]};
        case (a)
            12'h000: return m_pp[31:0];
            12'h004: return {24'b0, m_pp[39:32]};
            12'h020: return m_pe[31:0];
            12'h024: return {24'b0, m_pe[39:32]};
            12'h040: return 32'(m_idx());
            12'h050: return m_pm0;
            12'h054: return {24'b0, m_pm1};
            12'h060: return m_tm0;
            12'h064: return {24'b0, m_tm1};
            12'h080: return m_sp & m_se;
            12'h090: return m_se;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pp = '0; m_pe = '0; m_sp = '0; m_se = '0;
            for (int c = 0; c < 40; c++) m_ch[c] = 6'(c);
            m_pm0 = '0; m_tm0 = '0; m_pm1 = '0; m_tm1 = '0;
            m_rv = 1'b0; m_rd = '0; m_irq = 1'b0;
        end else begin
            m_rv = bus_req && !bus_we;
            if (m_rv) m_rd = m_read(bus_addr);
            m_sa = |(m_sp & m_se);
            m_lv = {irq_pri[39:1], irq_pri[0] | m_sa};
            if (bus_req && bus_we) begin
                if (bus_addr >= 12'h200 && bus_addr < 12'h2A0 && bus_addr[1:0] == 2'b00)
                    m_ch[(bus_addr - 12'h200) >> 2] = bus_wdata[5:0];
                case (bus_addr)
                    12'h010: m_pp[31:0]  = m_pp[31:0] & ~bus_wdata;
                    12'h014: m_pp[39:32] = m_pp[39:32] & ~bus_wdata[7:0];
                    12'h020: m_pe[31:0]  = m_pe[31:0] | bus_wdata;
                    12'h024: m_pe[39:32] = m_pe[39:32] | bus_wdata[7:0];
                    12'h030: m_pe[31:0]  = m_pe[31:0] & ~bus_wdata;
                    12'h034: m_pe[39:32] = m_pe[39:32] & ~bus_wdata[7:0];
                    12'h050: m_pm0 = bus_wdata;
                    12'h054: m_pm1 = bus_wdata[7:0];
                    12'h060: m_tm0 = bus_wdata;
                    12'h064: m_tm1 = bus_wdata[7:0];
                    12'h088: m_sp = m_sp & ~bus_wdata;
                    12'h090: m_se = m_se | bus_wdata;
                    12'h098: m_se = m_se & ~bus_wdata;
                    default: ;
                endcase
            end
            m_pp = m_pp | m_lv;
            m_sp = m_sp | irq_sec;
            m_irq = |(m_pp & m_pe);
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq_out !== m_irq) begin
                errors++;
                $display("FAIL R4 irq_out actual %0b expected %0b", irq_out, m_irq);
            end
            checks++;
            if (bus_rvalid !== m_rv) begin
                errors++;
                $display("FAIL R11 rvalid actual %0b expected %0b", bus_rvalid, m_rv);
            end
            if (m_rv) begin
                checks++;
                if (bus_rdata !== m_rd) begin
                    errors++;
                    $display("FAIL R11 rdata actual %h expected %h", bus_rdata, m_rd);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        chk({31'b0, bus_rvalid}, 32'h1, tag);
        chk(bus_rdata, e, tag);
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(negedge clk);
        chk({31'b0, irq_out}, {31'b0, e}, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        irq_chk(1'b0, "R1");
        rd_chk(12'h040, 32'h0, "R1");
        rd_chk(12'h020, 32'h0, "R1");
        rd_chk(12'h000, 32'h0, "R1");
        rd_chk(12'h214, 32'd5, "R1");
        wr(12'h030, 32'hFFFF_FFFF); wr(12'h034, 32'hFFFF_FFFF); wr(12'h098, 32'hFFFF_FFFF);
        wr(12'h010, 32'hFFFF_FFFF); wr(12'h014, 32'hFFFF_FFFF); wr(12'h088, 32'hFFFF_FFFF);
        rd_chk(12'h020, 32'h0, "R1");
        rd_chk(12'h090, 32'h0, "R1");

        // R3 latch while disabled, R4 no request
        irq_pri[7] = 1'b1;
        rd_chk(12'h000, 32'h80, "R3");
        irq_chk(1'b0, "R4");
        wr(12'h020, 32'h80);
        rd_chk(12'h020, 32'h80, "R2");
        irq_chk(1'b1, "R4");
        rd_chk(12'h040, 32'd7, "R5");
        wr(12'h020, 32'h0);
        rd_chk(12'h020, 32'h80, "R2");

        // R12 high word mapping
        irq_pri[35] = 1'b1;
        wr(12'h024, 32'h08);
        rd_chk(12'h024, 32'h08, "R12");
        rd_chk(12'h004, 32'h08, "R12");
        rd_chk(12'h040, 32'd7, "R5");

        // R3 hold after drop, ack
        irq_pri[7] = 1'b0;
        rd_chk(12'h000, 32'h80, "R3");
        wr(12'h010, 32'h80);
        rd_chk(12'h000, 32'h0, "R3");
        rd_chk(12'h040, 32'd35, "R5");
        wr(12'h014, 32'h08);
        rd_chk(12'h004, 32'h08, "R3");
        wr(12'h034, 32'h08);
        rd_chk(12'h024, 32'h0, "R2");
        irq_chk(1'b0, "R4");
        rd_chk(12'h040, 32'h0, "R5");

        // R6 cascade
        irq_sec[9] = 1'b1; irq_sec[4] = 1'b1;
        wr(12'h090, 32'h200);
        rd_chk(12'h080, 32'h200, "R6");
        rd_chk(12'h000, 32'h1, "R6");
        wr(12'h020, 32'h1);
        irq_chk(1'b1, "R6");
        rd_chk(12'h040, 32'h0, "R5");
        wr(12'h090, 32'h10);
        rd_chk(12'h080, 32'h210, "R6");

        // R7 line 0 acknowledge rules
        wr(12'h010, 32'h1);
        rd_chk(12'h000, 32'h1, "R7");
        irq_sec = '0;
        wr(12'h088, 32'hFFFF_FFFF);
        rd_chk(12'h080, 32'h0, "R6");
        rd_chk(12'h000, 32'h1, "R7");
        wr(12'h010, 32'h1);
        rd_chk(12'h000, 32'h0, "R7");
        irq_chk(1'b0, "R7");

        // R5 line 0 loses to a higher line
        irq_sec[4] = 1'b1;
        irq_pri[12] = 1'b1;
        wr(12'h020, 32'h1000);
        rd_chk(12'h040, 32'd12, "R5");
        irq_pri[12] = 1'b0;
        wr(12'h010, 32'h1000);
        rd_chk(12'h040, 32'h0, "R5");

        // R8 channel map
        wr(12'h20C, 32'hFFFF_FFFF);
        rd_chk(12'h20C, 32'h3F, "R8");
        rd_chk(12'h29C, 32'd39, "R8");

        // R9 mode words
        wr(12'h050, 32'h1234_5678);
        rd_chk(12'h050, 32'h1234_5678, "R9");
        wr(12'h054, 32'hFFFF_FFFF);
        rd_chk(12'h054, 32'hFF, "R9");
        wr(12'h064, 32'hA5);
        rd_chk(12'h064, 32'hA5, "R9");
        rd_chk(12'h060, 32'h0, "R9");

        // R10 undefined offsets
        wr(12'h044, 32'hFFFF_FFFF);
        wr(12'h2A0, 32'hFFFF_FFFF);
        wr(12'h022, 32'hFFFF_FFFF);
        wr(12'h032, 32'hFFFF_FFFF);
        rd_chk(12'h044, 32'h0, "R10");
        rd_chk(12'h2A0, 32'h0, "R10");
        rd_chk(12'h0C0, 32'h0, "R10");
        rd_chk(12'h010, 32'h0, "R10");
        rd_chk(12'h020, 32'h1081, "R10");

        // R11 back-to-back reads
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'h020;
        @(negedge clk);
        chk({31'b0, bus_rvalid}, 32'h1, "R11");
        chk(bus_rdata, 32'h1081, "R11");
        bus_addr = 12'h054;
        @(negedge clk);
        bus_req = 1'b0;
        chk({31'b0, bus_rvalid}, 32'h1, "R11");
        chk(bus_rdata, 32'hFF, "R11");
        @(negedge clk);
        chk({31'b0, bus_rvalid}, 32'h0, "R11");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule